// File: doc/BRIEF.md
# Halt and Wake-up Sequencer

This block manages a small controller's low-power halt. A one-cycle halt strobe from the core stops the system clock through a clock-enable output. It sets the power-down flag and clears the time-out flag. While halted, the block watches for three wake sources: a watchdog overflow, a newly raised interrupt request, and a falling edge on an enabled bit of an 8-bit wake port. The fourth source, an external reset, is the block's own synchronous reset, which returns every flag and output to its power-up state.

When a wake source is seen, the system clock is enabled again at once. A settling window of a fixed number of system-clock cycles then runs. At the end of the window the block issues exactly one single-cycle request, which tells the core how to continue: resume at the next instruction, take the interrupt vector, or perform a warm reset of the program counter and stack pointer. Interrupt requests that were already pending when the halt began are masked out as wake sources for that halt. Whether an interrupt wake vectors or resumes depends on that interrupt's enable and on whether the stack is full.

All logic runs on the always-on clock `clk`. The port pins are asynchronous and are synchronised inside the block.

Top module: `halt_wake_seq`

## Requirements
- R1: After reset `sys_clk_en_o` is 1, `pd_o` and `to_o` are 0, and `resume_o`, `irq_vec_o` and `warm_rst_o` are 0.
- R2: A `halt_i` strobe while running drives `sys_clk_en_o` to 0, `pd_o` to 1 and `to_o` to 0 from the next cycle on.
- R3: While halted, a falling edge on port bit i wakes the block only if `port_wake_en_i[i]` is 1. A falling edge on a disabled bit does not wake it, and neither does a rising edge on any bit. Port pins reach the detector through two synchronising flops and an edge register.
- R4: While halted, a 1 on `irq_req_i[i]` wakes the block only if that bit was 0 when the halt strobe was taken. Requests pending at halt entry cannot wake it.
- R5: `sys_clk_en_o` returns to 1 on the cycle after wake detection. The completion pulse follows exactly SETTLE_CYC cycles later (default 1024), and `sys_clk_en_o` stays 0 for the whole halted state.
- R6: An interrupt wake ends with `irq_vec_o` if at least one waking request has its `irq_en_i` bit set and `stack_full_i` is 0. Otherwise it ends with `resume_o`. A port wake always ends with `resume_o`.
- R7: A watchdog wake sets `to_o` together with the clock re-enable and ends with `warm_rst_o`. When several sources arrive in the same cycle, watchdog ranks above interrupt, and interrupt ranks above port.
- R8: While running, `wdt_clr_i` clears `pd_o`, unless a halt strobe arrives in the same cycle, in which case the halt wins. `halt_i` is ignored outside the running state. `wdt_ovf_i` is ignored outside the halted state.
- R9: Each wake produces exactly one of `resume_o`, `irq_vec_o` and `warm_rst_o`, high for a single cycle. No pulse occurs at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| halt_i | input | 1 | Halt instruction strobe |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| irq_req_i | input | NIRQ | Interrupt request flags |
| irq_en_i | input | NIRQ | Interrupt enables |
| stack_full_i | input | 1 | Return stack is full |
| port_pin_i | input | PA_W | Asynchronous wake port pins |
| port_wake_en_i | input | PA_W | Per-bit wake enable |
| sys_clk_en_o | output | 1 | System clock enable |
| pd_o | output | 1 | Power-down flag |
| to_o | output | 1 | Time-out flag |
| resume_o | output | 1 | Continue at the next instruction (pulse) |
| irq_vec_o | output | 1 | Take the interrupt vector (pulse) |
| warm_rst_o | output | 1 | Reset PC and SP only (pulse) |

## Verification
The bound checker checks the following on every cycle:
- the effect of a halt strobe on the clock enable and the flags;
- that the clock stays gated through the halted state;
- the exact length of the settling window, using a counter;
- that `to_o` is set whenever a warm reset issues;
- that `pd_o` clears on a watchdog-clear strobe;
- that the three completion pulses are one-hot and single-cycle.

Only the bench scenarios can show which stimuli actually wake the block: the per-bit port enable, rising edges, interrupts masked at halt entry, and priority between sources arriving in the same cycle. They also cover how the vector-or-resume choice follows the interrupt enables and stack fullness.

// File: rtl/hws_pkg.sv
// Shared types for the halt and wake-up sequencer.
package hws_pkg;
    typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_SETTLE} hws_state_e;
    typedef enum logic [1:0] {WK_NONE, WK_PORT, WK_IRQ, WK_WDT} hws_cause_e;
endpackage

// File: rtl/hws_port_edge.sv
// Port falling-edge detector.
// Each pin passes through two synchronising flops and then an edge register,
// all clocked by the always-on clock. The flops reset high (idle pin level),
// so leaving reset never produces a false edge.
// Assumes pins are asynchronous and held long enough to be sampled.
module hws_port_edge #(
    parameter int PA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PA_W-1:0] pin_i,
    output logic [PA_W-1:0] fall_o
);
    for (genvar g = 0; g < PA_W; g++) begin : g_bit
        logic sync1_q, sync2_q, prev_q;

        // Synchronise the pin and keep the previous synchronised level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync1_q <= 1'b1;
                sync2_q <= 1'b1;
                prev_q  <= 1'b1;
            end else begin
                sync1_q <= pin_i[g];
                sync2_q <= sync1_q;
                prev_q  <= sync2_q;
            end
        end

        assign fall_o[g] = prev_q & ~sync2_q;
    end
endmodule

// File: rtl/hws_wake_arb.sv
// Wake-source arbiter, purely combinational.
// Priority: watchdog, then a new interrupt, then an enabled port fall.
// Assumes irq_new_i is already masked against requests pending at halt entry.
module hws_wake_arb
    import hws_pkg::*;
#(
    parameter int NIRQ = 4,
    parameter int PA_W = 8
) (
    input  logic            wdt_ovf_i,
    input  logic [NIRQ-1:0] irq_new_i,
    input  logic [PA_W-1:0] port_fall_i,
    input  logic [PA_W-1:0] port_en_i,
    output logic            wake_o,
    output hws_cause_e      cause_o
);
    // Pick the highest-ranked source present this cycle.
    always_comb begin
        if (wdt_ovf_i)                        cause_o = WK_WDT;
        else if (|irq_new_i)                  cause_o = WK_IRQ;
        else if (|(port_fall_i & port_en_i))  cause_o = WK_PORT;
        else                                  cause_o = WK_NONE;
        wake_o = (cause_o != WK_NONE);
    end
endmodule

// File: rtl/hws_settle_cnt.sv
// Settling-window counter.
// Counts cycles while clear_i is low. done_o is high on the final cycle of the
// window, i.e. on the SETTLE_CYC-th cycle after clear_i falls.
// Assumes SETTLE_CYC >= 2.
module hws_settle_cnt #(
    parameter int SETTLE_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic done_o
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Advance through the window; hold at zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else              cnt_q <= cnt_q + CW'(1);
    end

    assign done_o = !clear_i && (cnt_q == LAST);
endmodule

// File: rtl/halt_wake_seq.sv
// Halt and wake-up sequencer (top).
// Behaviour:
//   - A halt strobe gates the system clock and updates the PD/TO flags.
//   - While halted, the block waits for a wake source.
//   - On wake, it re-enables the clock and counts a settling window.
//   - It then issues one request: resume, interrupt vector, or warm reset.
// Assumes clk is always running; rst_n is the external (cold) reset.
module halt_wake_seq
    import hws_pkg::*;
#(
    parameter int NIRQ       = 4,
    parameter int PA_W       = 8,
    parameter int SETTLE_CYC = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_i,
    input  logic            wdt_clr_i,
    input  logic            wdt_ovf_i,
    input  logic [NIRQ-1:0] irq_req_i,
    input  logic [NIRQ-1:0] irq_en_i,
    input  logic            stack_full_i,
    input  logic [PA_W-1:0] port_pin_i,
    input  logic [PA_W-1:0] port_wake_en_i,
    output logic            sys_clk_en_o,
    output logic            pd_o,
    output logic            to_o,
    output logic            resume_o,
    output logic            irq_vec_o,
    output logic            warm_rst_o
);
    hws_state_e      state_q;
    hws_cause_e      cause_q, cause_d;
    logic [NIRQ-1:0] pend_q, wmask_q, irq_new;
    logic [PA_W-1:0] port_fall;
    logic            wake_any, settle_done;

    hws_port_edge #(.PA_W(PA_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (port_pin_i),
        .fall_o (port_fall)
    );

    assign irq_new = irq_req_i & ~pend_q;

    hws_wake_arb #(.NIRQ(NIRQ), .PA_W(PA_W)) u_arb (
        .wdt_ovf_i   (wdt_ovf_i),
        .irq_new_i   (irq_new),
        .port_fall_i (port_fall),
        .port_en_i   (port_wake_en_i),
        .wake_o      (wake_any),
        .cause_o     (cause_d)
    );

    hws_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q != ST_SETTLE),
        .done_o  (settle_done)
    );

    // Sequencer state, flags and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_RUN;
            cause_q      <= WK_NONE;
            pend_q       <= '0;
            wmask_q      <= '0;
            sys_clk_en_o <= 1'b1;
            pd_o         <= 1'b0;
            to_o         <= 1'b0;
            resume_o     <= 1'b0;
            irq_vec_o    <= 1'b0;
            warm_rst_o   <= 1'b0;
        end else begin
            resume_o   <= 1'b0;
            irq_vec_o  <= 1'b0;
            warm_rst_o <= 1'b0;
            case (state_q)
                ST_RUN: begin
                    if (halt_i) begin
                        state_q      <= ST_HALT;
                        sys_clk_en_o <= 1'b0;
                        pd_o         <= 1'b1;
                        to_o         <= 1'b0;
                        pend_q       <= irq_req_i;
                    end else if (wdt_clr_i) begin
                        pd_o <= 1'b0;
                    end
                end
                ST_HALT: begin
                    if (wake_any) begin
                        state_q      <= ST_SETTLE;
                        sys_clk_en_o <= 1'b1;
                        cause_q      <= cause_d;
                        wmask_q      <= irq_new;
                        if (cause_d == WK_WDT) to_o <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        state_q <= ST_RUN;
                        case (cause_q)
                            WK_WDT:  warm_rst_o <= 1'b1;
                            WK_IRQ: begin
                                if (|(wmask_q & irq_en_i) && !stack_full_i)
                                    irq_vec_o <= 1'b1;
                                else
                                    resume_o <= 1'b1;
                            end
                            default: resume_o <= 1'b1;
                        endcase
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/hws_checker.sv
// Assertion checker for halt_wake_seq, attached with bind.
// Watches the ports plus the sequencer state. A local counter measures the
// settling window, so no long $past chains are needed.
module hws_checker
    import hws_pkg::*;
#(
    parameter int SETTLE_CYC = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input hws_state_e state_q,
    input logic       halt_i,
    input logic       wdt_clr_i,
    input logic       sys_clk_en_o,
    input logic       pd_o,
    input logic       to_o,
    input logic       resume_o,
    input logic       irq_vec_o,
    input logic       warm_rst_o
);
    logic [31:0] win_q;
    logic        any_pulse;

    assign any_pulse = resume_o | irq_vec_o | warm_rst_o;

    // Count the cycles spent in the settling window.
    always_ff @(posedge clk) begin
        if (!rst_n)                   win_q <= '0;
        else if (state_q == ST_HALT)  win_q <= '0;
        else if (state_q == ST_SETTLE) win_q <= win_q + 32'd1;
    end

    a_r2_halt_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && halt_i) |=> (!sys_clk_en_o && pd_o && !to_o));

    a_r5_gated_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> !sys_clk_en_o);

    a_r5_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |-> (win_q == 32'(SETTLE_CYC)));

    a_r7_warm_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_o |-> to_o);

    a_r8_pd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wdt_clr_i && !halt_i) |=> !pd_o);

    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_o, irq_vec_o, warm_rst_o}));

    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |=> !any_pulse);
endmodule

bind halt_wake_seq hws_checker #(.SETTLE_CYC(SETTLE_CYC)) i_hws_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .halt_i       (halt_i),
    .wdt_clr_i    (wdt_clr_i),
    .sys_clk_en_o (sys_clk_en_o),
    .pd_o         (pd_o),
    .to_o         (to_o),
    .resume_o     (resume_o),
    .irq_vec_o    (irq_vec_o),
    .warm_rst_o   (warm_rst_o)
);

// File: tb/test_halt_wake_seq.sv
// Self-checking bench: directed corners plus seeded random halt/wake rounds.
module test_halt_wake_seq;
    localparam int NIRQ = 4, PA_W = 8, SETTLE = 1024;
    localparam int K_PORT = 0, K_IRQ = 1, K_WDT = 2;
    localparam int P_RES = 0, P_VEC = 1, P_WARM = 2, P_NONE = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic halt = 0, wdt_clr = 0, wdt_ovf = 0, stack_full = 0;
    logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
    logic [PA_W-1:0] pins = '1, pa_en = '0;
    logic clk_en, pd, to, resume, vec, warm;
    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;

    halt_wake_seq #(.NIRQ(NIRQ), .PA_W(PA_W), .SETTLE_CYC(SETTLE)) i_halt_wake_seq (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .wdt_clr_i(wdt_clr),
        .wdt_ovf_i(wdt_ovf), .irq_req_i(irq_req), .irq_en_i(irq_en),
        .stack_full_i(stack_full), .port_pin_i(pins), .port_wake_en_i(pa_en),
        .sys_clk_en_o(clk_en), .pd_o(pd), .to_o(to), .resume_o(resume),
        .irq_vec_o(vec), .warm_rst_o(warm));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int pulse_now();
        if (resume) return P_RES;
        if (vec)    return P_VEC;
        if (warm)   return P_WARM;
        return P_NONE;
    endfunction

    // Expected completion request (R6, R7).
    function automatic int exp_pulse(input int kind, input logic [NIRQ-1:0] wmask,
                                     input logic [NIRQ-1:0] en, input logic sf);
        if (kind == K_WDT) return P_WARM;
        if (kind == K_IRQ && |(wmask & en) && !sf) return P_VEC;
        return P_RES;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // One halt/wake round. kind selects the source; b is the port or irq bit;
    // pre is the set of requests pending at halt entry; both adds a same-cycle
    // irq to a watchdog wake; hs pulses halt during the settling window.
    task automatic do_wake(input int kind, input int b, input logic [NIRQ-1:0] pre,
                           input bit both, input bit hs);
        int n, p, d;
        logic [NIRQ-1:0] wmask;
        wmask = '0;
        irq_req = pre;
        step(2);
        halt = 1; step(1); halt = 0;
        chk(!clk_en && pd && !to, "R2", {clk_en, pd, to}, 3'b010);
        // Non-waking stimulus: fall on a disabled bit, then a rising edge.
        d = -1;
        for (int i = 0; i < PA_W; i++) if (!pa_en[i]) d = i;
        if (d >= 0) begin
            pins[d] = 1'b0; step(6);
            chk(!clk_en, "R3 disabled bit", clk_en, 0);
            pins[d] = 1'b1; step(6);
            chk(!clk_en, "R3 rising edge", clk_en, 0);
        end
        if (pre != '0) chk(!clk_en, "R4 pending masked", clk_en, 0);
        case (kind)
            K_PORT: pins[b] = 1'b0;
            K_IRQ: begin irq_req[b] = 1'b1; wmask[b] = 1'b1; end
            default: begin
                wdt_ovf = 1'b1;
                if (both) irq_req[b] = 1'b1;
                step(1); wdt_ovf = 1'b0;
            end
        endcase
        while (!clk_en) step(1);
        chk(to == (kind == K_WDT), "R7 TO flag", to, kind == K_WDT);
        n = 0;
        while (pulse_now() == P_NONE) begin
            if (hs && n == 1) halt = 1;
            n++; step(1); halt = 0;
            if (hs && n == 2) chk(clk_en, "R8 halt ignored", clk_en, 1);
        end
        chk(n == SETTLE, "R5 window", n, SETTLE);
        p = exp_pulse(kind, wmask, irq_en, stack_full);
        chk(pulse_now() == p, "R6/R7 request", pulse_now(), p);
        step(1);
        chk(pulse_now() == P_NONE && clk_en, "R9 single pulse", pulse_now(), P_NONE);
        irq_req = '0; pins = '1;
        step(4);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        step(3);
        chk(clk_en && !pd && !to && pulse_now() == P_NONE, "R1 reset",
            {clk_en, pd, to}, 3'b100);
        rst_n = 1'b1;
        step(2);
        chk(clk_en && !pd && !to, "R1 after release", {clk_en, pd, to}, 3'b100);
        // R8: watchdog overflow while running is ignored.
        wdt_ovf = 1; step(1); wdt_ovf = 0; step(2);
        chk(!to && clk_en && pulse_now() == P_NONE, "R8 ovf in run", to, 0);
        // Directed corners.
        pa_en = 8'b0000_0100; irq_en = 4'b0001;
        do_wake(K_PORT, 2, 4'b0000, 0, 1);
        chk(pd, "R8 PD held after wake", pd, 1);
        wdt_clr = 1; step(1); wdt_clr = 0;
        chk(!pd, "R8 PD cleared", pd, 0);
        do_wake(K_IRQ, 0, 4'b0010, 0, 0);        // R6 enabled, stack free: vector
        stack_full = 1;
        do_wake(K_IRQ, 0, 4'b0000, 0, 0);        // R6 stack full: resume
        stack_full = 0;
        do_wake(K_IRQ, 3, 4'b0001, 0, 0);        // R6 disabled irq: resume
        do_wake(K_WDT, 1, 4'b0000, 1, 0);        // R7 priority over irq
        // Seeded random rounds.
        for (int r = 0; r < 40; r++) begin
            int kind, b;
            logic [NIRQ-1:0] pre;
            kind = $urandom_range(2, 0);
            irq_en = NIRQ'($urandom);
            stack_full = 1'($urandom_range(1, 0));
            pa_en = PA_W'($urandom) | 8'b1;
            if (kind == K_PORT) begin
                do b = $urandom_range(PA_W - 1, 0); while (!pa_en[b]);
            end else begin
                b = $urandom_range(NIRQ - 1, 0);
            end
            pre = NIRQ'($urandom);
            pre[b] = 1'b0;
            do_wake(kind, b, pre, 0, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule